// File: doc/BRIEF.md
# Triangle Spread-Spectrum Modulation Generator

This block produces a signed offset word for the fractional feedback divider of a clock synthesizer. Adding the word to a nominal feedback ratio of 80 makes the synthesized clock sweep its frequency along a linear triangle, which spreads the spectral energy of the clock and lowers its EMI peaks. The block runs on the reference clock and steps the offset once per reference cycle. The fractional-N modulator and the analog loop sit outside it.

A 2-bit select picks one of three profiles. In the one-sided profile the offset sweeps from zero down to about 0.6% below nominal and back, so the clock never runs faster than nominal. In the symmetric profile the offset swings between +0.125% and -0.125% of nominal. In the off profile the offset is held at zero. The step size and the bounds are derived at elaboration from the reference rate, the modulation rate, the ratio and the spread depths in parts per million. Each change of profile restarts the ramp at the nominal-frequency point, heading downward.

The offset uses 2^-FRAC_W of one feedback-divider unit as its LSB. At the defaults (16 fractional bits) the nominal ratio of 80 equals 5,242,880 LSBs. A half period takes 400 reference cycles.

Top module: `ssc_triangle_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `ssc_offset` is 0 and both `spread_on` and `center_on` are 0.
- R2: Select 11 means spreading is off: `ssc_offset` stays exactly 0, and `spread_on` and `center_on` are both 0.
- R3: Select 00 means down-spread: `spread_on`=1, `center_on`=0, and `ssc_offset` stays between -31200 and 0 at the defaults. It is never positive.
- R4: Select 01 and select 10 both mean center-spread: `spread_on`=1, `center_on`=1, and `ssc_offset` stays between -6400 and +6400 at the defaults.
- R5: While a spread profile is held, `ssc_offset` moves by exactly one step on every reference clock. The step is 78 LSBs for down-spread and 32 LSBs for center-spread at the defaults.
- R6: In down-spread the offset reaches -31200 exactly 400 clocks after the ramp starts at 0. It then rises and is back at 0 after 800 clocks, after which it descends again.
- R7: In center-spread the ramp starts at 0 and descends. It reaches -6400 after 200 clocks and +6400 after 600 clocks, and it reverses at each bound.
- R8: When the decoded profile changes, the offset is 0 on the first clock and the ramp then descends. Moving between select 01 and select 10 is not a profile change, and the ramp continues without a break.
- R9: The offset never goes below -0.7% of the nominal ratio, which is -36700 LSBs at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference-rate clock; the ramp steps once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_sel | input | 2 | Profile select: 00 down, 01/10 center, 11 off |
| ssc_offset | output | FRAC_W+2 | Signed offset added to the nominal feedback ratio, LSB = 2^-FRAC_W divider units |
| spread_on | output | 1 | High while a spread profile is in effect |
| center_on | output | 1 | High while the center-spread profile is in effect |

## Verification
The bench builds the block with its default parameters: 16 fractional bits, a 25 MHz reference, a 31.25 kHz modulation rate and no output stage. With these values a full triangle is only 800 clocks long, so the bench can step through complete down-spread and center-spread periods, including every reversal point, many times within one run. The short period also lets random profile switches and resets land at any phase of the ramp. This exercises the restart, the alias between the two center-spread codes and the 0.7% floor.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

   typedef enum logic [1:0] {
      SSC_DOWN   = 2'd0,
      SSC_CENTER = 2'd1,
      SSC_OFF    = 2'd2
   } ssc_mode_e;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } ssc_dir_e;

   // Scaled amount = ratio * 2^frac * ppm / 1e6, truncated.
   function automatic longint ppm_of_ratio(input longint ratio, input int frac_w,
                                           input longint ppm);
      return ((ratio << frac_w) * ppm) / 64'd1000000;
   endfunction

endpackage

// File: rtl/ssc_mode_decode.sv
module ssc_mode_decode
   import ssc_pkg::*;
(
   input  logic [1:0] sel_i,
   output ssc_mode_e  mode_o
);
   always_comb begin
      unique case (sel_i)
         2'b00:   mode_o = SSC_DOWN;
         2'b01,
         2'b10:   mode_o = SSC_CENTER;
         default: mode_o = SSC_OFF;
      endcase
   end
endmodule

// File: rtl/ssc_profile_sel.sv
module ssc_profile_sel
   import ssc_pkg::*;
#(
   parameter int     OFF_W   = 18,
   parameter longint STEP_DN = 78,
   parameter longint LO_DN   = -31200,
   parameter longint HI_DN   = 0,
   parameter longint STEP_CT = 32,
   parameter longint LO_CT   = -6400,
   parameter longint HI_CT   = 6400
) (
   input  ssc_mode_e                mode_i,
   output logic signed [OFF_W-1:0]  step_o,
   output logic signed [OFF_W-1:0]  lo_o,
   output logic signed [OFF_W-1:0]  hi_o
);
   always_comb begin
      unique case (mode_i)
         SSC_DOWN: begin
            step_o = OFF_W'(STEP_DN);
            lo_o   = OFF_W'(LO_DN);
            hi_o   = OFF_W'(HI_DN);
         end
         SSC_CENTER: begin
            step_o = OFF_W'(STEP_CT);
            lo_o   = OFF_W'(LO_CT);
            hi_o   = OFF_W'(HI_CT);
         end
         default: begin
            step_o = '0;
            lo_o   = '0;
            hi_o   = '0;
         end
      endcase
   end
endmodule

// File: rtl/ssc_ramp_core.sv
module ssc_ramp_core
   import ssc_pkg::*;
#(
   parameter int OFF_W = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart_i,
   input  logic                     active_i,
   input  logic signed [OFF_W-1:0]  step_i,
   input  logic signed [OFF_W-1:0]  lo_i,
   input  logic signed [OFF_W-1:0]  hi_i,
   output logic signed [OFF_W-1:0]  acc_o
);
   ssc_dir_e                dir_q;
   logic signed [OFF_W-1:0] acc_q;
   logic signed [OFF_W-1:0] next_dn;
   logic signed [OFF_W-1:0] next_up;

   assign next_dn = acc_q - step_i;
   assign next_up = acc_q + step_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         dir_q <= DIR_DOWN;
      end else if (restart_i || !active_i) begin
         acc_q <= '0;
         dir_q <= DIR_DOWN;
      end else if (dir_q == DIR_DOWN) begin
         if (next_dn <= lo_i) begin
            acc_q <= lo_i;
            dir_q <= DIR_UP;
         end else begin
            acc_q <= next_dn;
         end
      end else begin
         if (next_up >= hi_i) begin
            acc_q <= hi_i;
            dir_q <= DIR_DOWN;
         end else begin
            acc_q <= next_up;
         end
      end
   end

   assign acc_o = acc_q;

   // R5: a held profile moves the ramp by exactly one step per clock
   assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !restart_i) |=>
         ((acc_q == $past(acc_q) + $past(step_i)) ||
          (acc_q == $past(acc_q) - $past(step_i))));

   // R8: a restart puts the ramp at zero heading downward
   assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (acc_q == '0 && dir_q == DIR_DOWN));

endmodule

// File: rtl/ssc_triangle_gen.sv
module ssc_triangle_gen
   import ssc_pkg::*;
#(
   parameter int     FRAC_W     = 16,
   parameter longint RATIO      = 80,
   parameter longint REF_HZ     = 25000000,
   parameter longint MOD_HZ     = 31250,
   parameter longint DOWN_PPM   = 6000,
   parameter longint CENTER_PPM = 1250,
   parameter longint LIMIT_PPM  = 7000,
   parameter bit     OUT_REG    = 1'b0
) (
   input  logic                      clk_ref,
   input  logic                      rst_n,
   input  logic [1:0]                spread_sel,
   output logic signed [FRAC_W+1:0]  ssc_offset,
   output logic                      spread_on,
   output logic                      center_on
);
   localparam int     OFF_W    = FRAC_W + 2;
   localparam longint HALF_CYC = REF_HZ / (2 * MOD_HZ);
   localparam longint DN_REQ   = ppm_of_ratio(RATIO, FRAC_W, DOWN_PPM);
   localparam longint CT_REQ   = ppm_of_ratio(RATIO, FRAC_W, CENTER_PPM);
   localparam longint FLOOR    = ppm_of_ratio(RATIO, FRAC_W, LIMIT_PPM);
   localparam longint STEP_DN  = DN_REQ / HALF_CYC;
   localparam longint PEAK_DN  = STEP_DN * HALF_CYC;
   localparam longint STEP_CT  = (2 * CT_REQ) / HALF_CYC;
   localparam longint AMP_CT   = STEP_CT * (HALF_CYC / 2);

   // Elaboration-time parameter checks
   if (FRAC_W < 16) begin : g_chk_frac
      $error("ssc_triangle_gen: FRAC_W must be at least 16");
   end
   if (HALF_CYC < 2 || (HALF_CYC % 2) != 0) begin : g_chk_half
      $error("ssc_triangle_gen: half period must be an even count of at least 2");
   end
   if (STEP_DN < 1 || STEP_CT < 1) begin : g_chk_step
      $error("ssc_triangle_gen: spread depth too small for the half period");
   end
   if (PEAK_DN > FLOOR) begin : g_chk_floor
      $error("ssc_triangle_gen: down-spread depth exceeds the limit");
   end
   if (FLOOR >= (64'sd1 <<< (OFF_W - 2))) begin : g_chk_width
      $error("ssc_triangle_gen: offset word too narrow");
   end

   ssc_mode_e               mode_dec;
   ssc_mode_e               mode_q;
   logic                    restart;
   logic                    active;
   logic signed [OFF_W-1:0] step_w;
   logic signed [OFF_W-1:0] lo_w;
   logic signed [OFF_W-1:0] hi_w;
   logic signed [OFF_W-1:0] acc_w;

   ssc_mode_decode u_decode (
      .sel_i  (spread_sel),
      .mode_o (mode_dec)
   );

   ssc_profile_sel #(
      .OFF_W   (OFF_W),
      .STEP_DN (STEP_DN),
      .LO_DN   (-PEAK_DN),
      .HI_DN   (64'sd0),
      .STEP_CT (STEP_CT),
      .LO_CT   (-AMP_CT),
      .HI_CT   (AMP_CT)
   ) u_profile (
      .mode_i (mode_dec),
      .step_o (step_w),
      .lo_o   (lo_w),
      .hi_o   (hi_w)
   );

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) mode_q <= SSC_OFF;
      else        mode_q <= mode_dec;
   end

   assign restart = (mode_dec != mode_q);
   assign active  = (mode_dec != SSC_OFF);

   ssc_ramp_core #(.OFF_W(OFF_W)) u_ramp (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .restart_i (restart),
      .active_i  (active),
      .step_i    (step_w),
      .lo_i      (lo_w),
      .hi_i      (hi_w),
      .acc_o     (acc_w)
   );

   if (OUT_REG) begin : g_out_reg
      logic signed [OFF_W-1:0] off_q;
      logic                    spr_q;
      logic                    ctr_q;
      always_ff @(posedge clk_ref or negedge rst_n) begin
         if (!rst_n) begin
            off_q <= '0;
            spr_q <= 1'b0;
            ctr_q <= 1'b0;
         end else begin
            off_q <= acc_w;
            spr_q <= (mode_q != SSC_OFF);
            ctr_q <= (mode_q == SSC_CENTER);
         end
      end
      assign ssc_offset = off_q;
      assign spread_on  = spr_q;
      assign center_on  = ctr_q;
   end else begin : g_out_direct
      assign ssc_offset = acc_w;
      assign spread_on  = (mode_q != SSC_OFF);
      assign center_on  = (mode_q == SSC_CENTER);
   end

   // R2: the off profile holds the ramp at zero
   assert_off_zero_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (mode_q == SSC_OFF) |-> (acc_w == '0));

   // R3: down-spread never raises the frequency above nominal
   assert_down_nonpos_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (mode_q == SSC_DOWN) |-> (acc_w <= 0 && acc_w >= OFF_W'(-PEAK_DN)));

   // R4: center-spread stays within its symmetric bounds
   assert_center_bounds_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (mode_q == SSC_CENTER) |-> (acc_w <= OFF_W'(AMP_CT) && acc_w >= OFF_W'(-AMP_CT)));

   // R9: the deviation never goes past the limit below nominal
   assert_floor_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      acc_w >= OFF_W'(-FLOOR));

endmodule

// File: tb/ssc_triangle_gen_tb.sv
module ssc_triangle_gen_tb;
   localparam int STEP_D = 78;
   localparam int PEAK_D = 31200;
   localparam int STEP_C = 32;
   localparam int AMP_C  = 6400;
   localparam int HALF   = 400;
   localparam int FLOOR  = -36700;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic               rst_n = 1'b0;
   logic [1:0]         sel   = 2'b11;
   logic signed [17:0] off;
   logic               spr, ctr;

   int checks = 0, fails = 0;
   int m_mode = 2;
   int n = 0;
   int prev_off = 0;
   int prev_mode = 2;
   int min_seen = 0;

   ssc_triangle_gen u_dut (
      .clk_ref    (clk),
      .rst_n      (rst_n),
      .spread_sel (sel),
      .ssc_offset (off),
      .spread_on  (spr),
      .center_on  (ctr)
   );

   function automatic int dec(input logic [1:0] s);
      if (s == 2'b00) return 0;
      if (s == 2'b11) return 2;
      return 1;
   endfunction

   function automatic int exp_off(input int md, input int k);
      int u;
      if (md == 0) begin
         u = k % (2 * HALF);
         return (u <= HALF) ? -u * STEP_D : -(2 * HALF - u) * STEP_D;
      end else if (md == 1) begin
         u = (k + HALF / 2) % (2 * HALF);
         return (u <= HALF) ? AMP_C - u * STEP_C : -AMP_C + (u - HALF) * STEP_C;
      end
      return 0;
   endfunction

   // Reference model advances on the active edge; inputs only move at negedge.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode <= 2;
         n      <= 0;
      end else if (dec(sel) != m_mode) begin
         m_mode <= dec(sel);
         n      <= 0;
      end else if (n < 1000000) begin
         n <= n + 1;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         if (int'(off) < min_seen) min_seen = int'(off);
         if (m_mode == 0) begin
            chk("R3 R6 down offset", off, exp_off(0, n));
            chk("R3 flags", {spr, ctr}, 2'b10);
         end else if (m_mode == 1) begin
            chk("R4 R7 center offset", off, exp_off(1, n));
            chk("R4 flags", {spr, ctr}, 2'b11);
         end else begin
            chk("R2 off offset", off, 0);
            chk("R2 flags", {spr, ctr}, 2'b00);
         end
         if (n == 0 && m_mode != 2 && prev_mode != m_mode)
            chk("R8 restart at zero", off, 0);
         if (n > 0 && m_mode != 2 && prev_mode == m_mode)
            chk("R5 step size", (off > prev_off) ? off - prev_off : prev_off - off,
                (m_mode == 0) ? STEP_D : STEP_C);
         prev_off  = int'(off);
         prev_mode = m_mode;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 reset offset", off, 0);
      chk("R1 reset flags", {spr, ctr}, 2'b00);
      @(negedge clk);
      rst_n = 1'b1;
      prev_mode = 2;
      prev_off  = 0;
      tick(1);
      if (sel == 2'b11) chk("R1 after release", off, 0);
   endtask

   initial begin
      #1500000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int saved;
      void'($urandom(32'h5eed1234));
      sel = 2'b11;
      repeat (3) @(negedge clk);
      do_reset();
      tick(5);

      // R6: full down-spread period
      sel = 2'b00;
      tick(401);
      chk("R6 down bottom", off, -PEAK_D);
      tick(400);
      chk("R6 down back to nominal", off, 0);
      tick(1);
      chk("R6 descends again", off, -STEP_D);

      // R7: center-spread period
      sel = 2'b01;
      tick(201);
      chk("R7 center low", off, -AMP_C);
      tick(400);
      chk("R7 center high", off, AMP_C);

      // R8: alias 01 -> 10 keeps the ramp going
      sel = 2'b11;
      tick(3);
      sel = 2'b01;
      tick(101);
      saved = int'(off);
      sel = 2'b10;
      tick(1);
      chk("R8 alias no restart", off, saved - STEP_C);

      // R8: mid-ramp change of profile
      sel = 2'b00;
      tick(1);
      chk("R8 switch restarts", off, 0);
      tick(1);
      chk("R8 restart descends", off, -STEP_D);

      // R1: reset in the middle of a ramp
      tick(250);
      sel = 2'b11;
      do_reset();

      // Random profile mix
      for (int it = 0; it < 60; it++) begin
         sel = 2'($urandom % 4);
         if ($urandom % 10 == 0) do_reset();
         tick(1 + int'($urandom % 900));
      end

      chk("R9 deepest offset within limit", (min_seen >= FLOOR) ? 1 : 0, 1);
      chk("R3 deepest offset reached", min_seen, -PEAK_D);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule